// File: doc/BRIEF.md
# Status Packet Serializer

This block turns a 26-bit status word into a four-byte packet on an 8-bit link. When it has something to report, it raises a request line and presents a header byte. The header holds a 6-bit sequence tag in its upper bits and the two lowest status bits below them. When the receiver acknowledges that header, the block captures the whole status word in the same cycle. It then sends the other 24 status bits, lowest byte first, on the next three cycles. Every byte of a packet therefore comes from one snapshot.

Software controls the block with a single byte written to one configuration address, which is a parameter. The two top bits of that byte choose how packets are triggered: off, a single packet, or a new packet whenever the status word differs from the last one sent. The six low bits set the sequence tag carried in every following header. Outside a packet, the data output stays at zero.

Top module: `stpk_top`

## Requirements
- R1: After reset the request output is low, the data output is zero and the trigger mode is off.
- R2: A configuration write (cfg_we high, cfg_addr equal to CTRL_ADDR) with cfg_wdata[7:6] = 2'b01 raises pkt_req on the next cycle, and header bits [7:2] then equal cfg_wdata[5:0].
- R3: While pkt_req is high, pkt_data is the header {sequence tag, status_in[1:0]}, taken from status_in in the same cycle.
- R4: When pkt_ack is high while pkt_req is high, the next three cycles carry status[9:2], status[17:10] and status[25:18] of the status_in value seen in the acknowledge cycle, and pkt_req stays low during those three cycles.
- R5: pkt_data is zero in every cycle in which the block neither requests nor sends a tail byte.
- R6: In single-packet mode (cfg_wdata[7:6] = 2'b01), once the packet has been sent, changes of status_in raise no further request until a new configuration write arrives.
- R7: In change-tracking mode (cfg_wdata[7:6] = 2'b11), the write itself raises a request. After a packet, any difference between status_in and the snapshot last sent raises a request, which appears once the tail bytes are done. An unchanged status raises none.
- R8: A configuration write with cfg_wdata[7:6] = 2'b00 or 2'b10 selects off mode and withdraws a pending request, and status changes then raise none.
- R9: Writes whose cfg_addr differs from CTRL_ADDR change nothing.
- R10: pkt_ack while pkt_req is low has no effect: pkt_data stays zero and no tail bytes follow.
- R11: If a configuration write and an accepted acknowledge fall in the same cycle, the header already sent keeps the old tag, and the new mode decides whether a request follows the tail bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (5) | Configuration write address |
| cfg_wdata | input | 8 | Configuration value: [7:6] mode, [5:0] sequence tag |
| status_in | input | PAYLOAD_W (26) | Status word to report |
| pkt_req | output | 1 | A packet is waiting for its header to be taken |
| pkt_ack | input | 1 | Receiver takes the header this cycle |
| pkt_data | output | 8 | Packet byte stream, zero when idle |

## Verification
The properties assume that pkt_ack has meaning only in a cycle where pkt_req is high. They assume status_in may change on any cycle, including during a packet. No assertion constrains either input. The random stimulus raises pkt_ack on about half of all cycles regardless of pkt_req. It changes status_in freely, including while tail bytes are in flight, and it sometimes issues configuration writes to the wrong address or on an acknowledge cycle. This exercises the ignore, snapshot and collision rules as well as the normal flow.

// File: rtl/stpk_pkg.sv
package stpk_pkg;
    localparam int BYTE_W    = 8;
    localparam int HDR_PAY_W = 2;
    localparam int SEQ_W     = BYTE_W - HDR_PAY_W;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ONCE = 2'd1,
        MODE_RSVD = 2'd2,
        MODE_AUTO = 2'd3
    } trig_mode_e;
endpackage

// File: rtl/stpk_cfg.sv
module stpk_cfg
    import stpk_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              hit,
    output trig_mode_e        new_mode,
    output trig_mode_e        mode_q,
    output logic [SEQ_W-1:0]  seq_q
);
    typedef struct packed {
        trig_mode_e       mode;
        logic [SEQ_W-1:0] seq;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        hit      = we && (addr == CTRL_ADDR);
        new_mode = trig_mode_e'(wdata[BYTE_W-1 -: 2]);
        if (hit) begin
            cfg_d.mode = new_mode;
            cfg_d.seq  = wdata[SEQ_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{mode: MODE_OFF, seq: '0};
        else     cfg_q <= cfg_d;
    end

    assign mode_q = cfg_q.mode;
    assign seq_q  = cfg_q.seq;
endmodule

// File: rtl/stpk_trigger.sv
module stpk_trigger
    import stpk_pkg::*;
#(
    parameter int PAYLOAD_W = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PAYLOAD_W-1:0] status,
    input  logic                 take,
    input  logic                 hit,
    input  trig_mode_e           new_mode,
    input  trig_mode_e           mode_q,
    output logic                 pend
);
    typedef struct packed {
        logic                 pend;
        logic [PAYLOAD_W-1:0] last;
    } trg_t;

    trg_t trg_d, trg_q;

    always_comb begin
        trg_d = trg_q;
        if (take) begin
            trg_d.pend = 1'b0;
            trg_d.last = status;
        end else if (mode_q == MODE_AUTO && status != trg_q.last) begin
            trg_d.pend = 1'b1;
        end
        if (hit) begin
            trg_d.pend = (new_mode == MODE_ONCE) || (new_mode == MODE_AUTO);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trg_q <= '0;
        else     trg_q <= trg_d;
    end

    assign pend = trg_q.pend;
endmodule

// File: rtl/stpk_serializer.sv
module stpk_serializer
    import stpk_pkg::*;
#(
    parameter int PAYLOAD_W = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 req,
    input  logic [SEQ_W-1:0]     seq,
    input  logic [PAYLOAD_W-1:0] status,
    output logic                 busy,
    output logic [BYTE_W-1:0]    data
);
    localparam int TAIL_W = PAYLOAD_W - HDR_PAY_W;
    localparam int TAIL_N = (TAIL_W + BYTE_W - 1) / BYTE_W;
    localparam int CNT_W  = $clog2(TAIL_N + 1);
    localparam int SH_W   = TAIL_N * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (take) begin
            ser_d.cnt = CNT_W'(TAIL_N);
            ser_d.sh  = SH_W'(status[PAYLOAD_W-1:HDR_PAY_W]);
        end else if (ser_q.cnt != '0) begin
            ser_d.cnt = ser_q.cnt - CNT_W'(1);
            ser_d.sh  = ser_q.sh >> BYTE_W;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ser_q <= '0;
        else     ser_q <= ser_d;
    end

    assign busy = (ser_q.cnt != '0);

    always_comb begin
        if (busy)     data = ser_q.sh[BYTE_W-1:0];
        else if (req) data = {seq, status[HDR_PAY_W-1:0]};
        else          data = '0;
    end
endmodule

// File: rtl/stpk_top.sv
module stpk_top
    import stpk_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1C,
    parameter int                PAYLOAD_W = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic [PAYLOAD_W-1:0] status_in,
    output logic                 pkt_req,
    input  logic                 pkt_ack,
    output logic [7:0]           pkt_data
);
    logic             cfg_hit;
    trig_mode_e       wr_mode;
    trig_mode_e       cur_mode;
    logic [SEQ_W-1:0] cur_seq;
    logic             pend;
    logic             ser_busy;
    logic             take;

    assign pkt_req = pend && !ser_busy;
    assign take    = pkt_req && pkt_ack;

    stpk_cfg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .hit      (cfg_hit),
        .new_mode (wr_mode),
        .mode_q   (cur_mode),
        .seq_q    (cur_seq)
    );

    stpk_trigger #(.PAYLOAD_W(PAYLOAD_W)) u_trg (
        .clk      (clk),
        .rst      (rst),
        .status   (status_in),
        .take     (take),
        .hit      (cfg_hit),
        .new_mode (wr_mode),
        .mode_q   (cur_mode),
        .pend     (pend)
    );

    stpk_serializer #(.PAYLOAD_W(PAYLOAD_W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .req    (pkt_req),
        .seq    (cur_seq),
        .status (status_in),
        .busy   (ser_busy),
        .data   (pkt_data)
    );
endmodule

// File: rtl/stpk_chk.sv
module stpk_chk #(
    parameter int                ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h1C,
    parameter int                PAYLOAD_W = 26
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_we,
    input logic [ADDR_W-1:0]    cfg_addr,
    input logic [7:0]           cfg_wdata,
    input logic [PAYLOAD_W-1:0] status_in,
    input logic                 pkt_req,
    input logic                 pkt_ack,
    input logic [7:0]           pkt_data,
    input logic                 ser_busy
);
    // R4
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_req && pkt_ack) |=> !pkt_req);

    // R4
    first_tail_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_req && pkt_ack) |=> (pkt_data == $past(status_in[9:2])));

    // R3
    hdr_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_req |-> (pkt_data[1:0] == status_in[1:0]));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!pkt_req && !ser_busy) |-> (pkt_data == 8'h00));

    // R2
    once_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CTRL_ADDR && cfg_wdata[7:6] == 2'b01 && !ser_busy
         && !(pkt_req && pkt_ack))
        |=> (pkt_req && pkt_data[7:2] == $past(cfg_wdata[5:0])));
endmodule

bind stpk_top stpk_chk #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .PAYLOAD_W(PAYLOAD_W)
) u_stpk_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .status_in (status_in),
    .pkt_req   (pkt_req),
    .pkt_ack   (pkt_ack),
    .pkt_data  (pkt_data),
    .ser_busy  (ser_busy)
);

// File: tb/test_stpk_top.sv
`timescale 1ns/1ps
module test_stpk_top;
    localparam int             AW = 5;
    localparam int             PW = 26;
    localparam logic [AW-1:0]  CA = 5'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [PW-1:0] status_in = '0;
    logic          pkt_req;
    logic          pkt_ack = 1'b0;
    logic [7:0]    pkt_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state derived from the requirements
    logic [1:0]    m_mode;
    logic [5:0]    m_seq;
    logic          m_pend;
    logic [PW-1:0] m_last;
    int            m_cnt;
    logic [23:0]   m_sh;

    always #2.5 clk = ~clk;

    stpk_top #(.ADDR_W(AW), .CTRL_ADDR(CA), .PAYLOAD_W(PW)) i_stpk_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .status_in(status_in), .pkt_req(pkt_req),
        .pkt_ack(pkt_ack), .pkt_data(pkt_data)
    );

    function automatic logic exp_req_f();
        return m_pend && (m_cnt == 0);
    endfunction

    function automatic logic [7:0] exp_data_f(input logic [PW-1:0] st);
        if (m_cnt != 0)   return m_sh[7:0];
        if (exp_req_f())  return {m_seq, st[1:0]};
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [AW-1:0] a, input logic [7:0] wd,
                        input logic [PW-1:0] st, input logic ack, input string tag);
        logic  er;
        logic  take;
        logic  hit;
        string t;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = wd; status_in = st; pkt_ack = ack;
        #1;
        er = exp_req_f();
        t  = tag;
        if (t == "") t = (m_cnt != 0) ? "R4" : (er ? "R3" : "R5");
        chk(t, "pkt_req", 32'(pkt_req), 32'(er));
        chk(t, "pkt_data", 32'(pkt_data), 32'(exp_data_f(st)));
        @(posedge clk);
        take = er && ack;
        hit  = we && (a == CA);
        if (take) begin
            m_cnt = 3;
            m_sh  = st[PW-1:2];
        end else if (m_cnt != 0) begin
            m_cnt--;
            m_sh = m_sh >> 8;
        end
        if (take) begin
            m_pend = 1'b0;
            m_last = st;
        end else if (m_mode == 2'b11 && st != m_last) begin
            m_pend = 1'b1;
        end
        if (hit) begin
            m_pend = (wd[7:6] == 2'b01) || (wd[7:6] == 2'b11);
            m_mode = wd[7:6];
            m_seq  = wd[5:0];
        end
    endtask

    task automatic idle(input logic [PW-1:0] st, input string tag);
        step(1'b0, '0, 8'h00, st, 1'b0, tag);
    endtask

    initial begin
        logic [PW-1:0] st;
        void'($urandom(32'd7193));
        m_mode = 2'b00; m_seq = '0; m_pend = 1'b0; m_last = '0; m_cnt = 0; m_sh = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        st = 26'h2AB_CDEF;
        idle(st, "R1");
        idle(st, "R1");

        // R2: single-packet write raises request with new tag
        step(1'b1, CA, {2'b01, 6'h2A}, st, 1'b0, "R2");
        idle(st, "R2");
        // R3: header follows live status while waiting
        st = 26'h155_5556; idle(st, "R3");
        st = 26'h3FF_FFFF; idle(st, "R3");
        // R4: acknowledge then three tail bytes from snapshot
        st = 26'h1C3_5A69;
        step(1'b0, '0, 8'h00, st, 1'b1, "R4");
        idle(26'h0, "R4"); idle(26'h0, "R4"); idle(26'h3FF_FFFF, "R4");
        idle(26'h3FF_FFFF, "R5");
        // R6: no re-trigger in single mode
        idle(26'h000_1234, "R6"); idle(26'h2FF_0000, "R6"); idle(26'h2FF_0001, "R6");
        // R10: stray acknowledge
        step(1'b0, '0, 8'h00, 26'h111_1111, 1'b1, "R10");
        idle(26'h111_1111, "R10"); idle(26'h111_1111, "R10");
        // R9: wrong address ignored
        step(1'b1, CA ^ 5'h01, {2'b01, 6'h3F}, st, 1'b0, "R9");
        idle(st, "R9"); idle(st, "R9");

        // R7: change tracking mode
        st = 26'h0AA_0055;
        step(1'b1, CA, {2'b11, 6'h15}, st, 1'b0, "R7");
        idle(st, "R7");
        step(1'b0, '0, 8'h00, st, 1'b1, "R7");
        st = 26'h0AA_0056;                   // change during tail bytes
        idle(st, "R7"); idle(st, "R7"); idle(st, "R7");
        idle(st, "R7");                      // request appears after tail
        step(1'b0, '0, 8'h00, st, 1'b1, "R7");
        idle(st, "R7"); idle(st, "R7"); idle(st, "R7");
        idle(st, "R7"); idle(st, "R7");      // unchanged: no request

        // R8: off mode withdraws pending and stops tracking
        step(1'b1, CA, {2'b01, 6'h01}, st, 1'b0, "R8");
        idle(st, "R8");
        step(1'b1, CA, {2'b00, 6'h02}, st, 1'b0, "R8");
        idle(st, "R8");
        step(1'b1, CA, {2'b11, 6'h03}, st, 1'b0, "R8");
        step(1'b1, CA, {2'b10, 6'h04}, st, 1'b0, "R8");
        idle(26'h123_4567, "R8"); idle(26'h321_7654, "R8");

        // R11: write and acknowledge in the same cycle
        step(1'b1, CA, {2'b01, 6'h0F}, st, 1'b0, "R11");
        idle(st, "R11");
        step(1'b1, CA, {2'b01, 6'h33}, st, 1'b1, "R11");
        idle(st, "R11"); idle(st, "R11"); idle(st, "R11");
        idle(st, "R11"); idle(st, "R11");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic          we;
            logic [AW-1:0] a;
            logic [7:0]    wd;
            we = ($urandom_range(15) == 0);
            a  = ($urandom_range(7) == 0) ? AW'($urandom) : CA;
            wd = 8'($urandom);
            if ($urandom_range(5) == 0) st = PW'($urandom);
            step(we, a, wd, st, 1'($urandom_range(1)), "");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule